// File: doc/BRIEF.md
# Single-Cycle Subset RISC Core

This block is a small processor core that completes every instruction in one clock: fetch, decode, register read, ALU operation, data-memory access and register write-back all settle between two rising edges. It runs a nine-instruction subset: word load, word store, add, subtract, bitwise and, bitwise or, signed set-less-than, branch-if-equal and an absolute jump. Instruction and data storage are two separate word arrays inside the core. The adders for sequential fetch and for the branch target are separate from the ALU, so no resource is shared within a cycle.

The memories are filled through a preload port. The port carries a select bit that chooses the instruction or the data array, a word index and a data word. The usual sequence is to hold reset, preload both arrays and then release reset. The core then fetches from address 0. Each cycle's register write-back and data-memory store are brought out as ports, so the effect of every instruction can be observed from outside.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears all 32 registers.
- R2: An instruction that is not a taken branch or a jump moves the PC to PC + 4 on the next rising edge. This includes unknown opcodes.
- R3: R-type instructions (opcode 0) take funct 0x20 add, 0x22 subtract (rs − rt), 0x24 and, 0x25 or, and 0x2A signed set-less-than. The result is written to rd (bits [15:11]). rs is bits [25:21] and rt is bits [20:16].
- R4: Register 0 always reads as zero. A write aimed at it is ignored.
- R5: A load (opcode 0x23) reads the data word at byte address rs + sign-extended bits [15:0] and writes it to rt.
- R6: A store (opcode 0x2B) writes rt's value to the data word at byte address rs + sign-extended offset, and writes no register.
- R7: A branch-if-equal (opcode 0x04) with rs equal to rt sets the PC to PC + 4 + (sign-extended offset × 4). When rs and rt differ it falls through to PC + 4.
- R8: A jump (opcode 0x02) sets the PC to the upper 4 bits of PC + 4 joined with bits [25:0] × 4.
- R9: The register write strobe is high only for R-type instructions and loads. The data-memory write strobe is high only for stores. An unknown opcode or funct writes nothing.
- R10: A preload write with select 0 stores a word into the instruction array, and with select 1 into the data array, at the given word index on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pre_we | input | 1 | Preload write strobe |
| pre_dsel | input | 1 | Preload target: 0 instruction array, 1 data array |
| pre_addr | input | PRE_AW | Preload word index |
| pre_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| rf_we_o | output | 1 | Register write-back strobe this cycle |
| rf_waddr_o | output | 5 | Register write-back destination |
| rf_wdata_o | output | 32 | Register write-back value |
| dm_we_o | output | 1 | Data store strobe this cycle |
| dm_addr_o | output | 32 | Data byte address (ALU result) |
| dm_wdata_o | output | 32 | Data store value |

## Verification
The bench builds the core with a 32-word instruction array, a 16-word data array and a 6-bit preload index. This keeps every address it uses inside both arrays. A 21-word program fits, with a forward branch, a forward jump and a backward branch whose negative offset lands exactly on address 0. With the small data array, a store lands at a word that a later load reads back. Under these sizes the trace per cycle can be written as a table. Poisoned words sit in the skipped slots, so a wrong next-PC shows up as a stray store.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_JUMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    AC_ADD   = 2'd0,
    AC_SUB   = 2'd1,
    AC_FUNCT = 2'd2
  } alu_class_e;

  typedef struct packed {
    logic    dst_is_rd;
    logic    b_is_imm;
    logic    wb_from_mem;
    logic    reg_write;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

  function automatic logic [31:0] sext16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] branch_target(input logic [31:0] pc_plus4,
                                                input logic [15:0] offs);
    return pc_plus4 + {sext16(offs)[29:0], 2'b00};
  endfunction

  function automatic logic [31:0] jump_target(input logic [31:0] pc_plus4,
                                              input logic [25:0] idx);
    return {pc_plus4[31:28], idx, 2'b00};
  endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  alu_class_e cls;
  alu_op_e    fop;
  logic       fn_ok;

  // second-level decode of the funct field
  always_comb begin
    fn_ok = 1'b1;
    fop   = ALU_ADD;
    unique case (funct)
      FN_ADD:  fop = ALU_ADD;
      FN_SUB:  fop = ALU_SUB;
      FN_AND:  fop = ALU_AND;
      FN_OR:   fop = ALU_OR;
      FN_SLT:  fop = ALU_SLT;
      default: fn_ok = 1'b0;
    endcase
  end

  // main decode from the opcode
  always_comb begin
    ctrl = '0;
    cls  = AC_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_write = fn_ok;
        cls            = AC_FUNCT;
      end
      OP_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_write   = 1'b1;
      end
      OP_STORE: begin
        ctrl.b_is_imm  = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        cls         = AC_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ;
    endcase
    unique case (cls)
      AC_SUB:   ctrl.alu_op = ALU_SUB;
      AC_FUNCT: ctrl.alu_op = fop;
      default:  ctrl.alu_op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);

  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd
);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
  parameter int WORDS = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int PRE_AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pre_we,
  input  logic              pre_dsel,
  input  logic [PRE_AW-1:0] pre_addr,
  input  logic [31:0]       pre_data,
  output logic [31:0]       pc_o,
  output logic [31:0]       instr_o,
  output logic              rf_we_o,
  output logic [4:0]        rf_waddr_o,
  output logic [31:0]       rf_wdata_o,
  output logic              dm_we_o,
  output logic [31:0]       dm_addr_o,
  output logic [31:0]       dm_wdata_o
);

  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [31:0] pc, pc4, pc_nxt, instr;
  logic [31:0] rs_data, rt_data, imm_ext, alu_b, alu_y, dm_rdata;
  logic        alu_zero, take_br, take_j;
  logic [4:0]  dst;
  ctrl_t       ctrl;

  // preload targeting
  logic pre_i_hit, pre_d_hit, store_now, dm_we;
  logic [DAW-1:0] dm_waddr;
  logic [31:0]    dm_wval;

  assign pre_i_hit = pre_we && !pre_dsel && (pre_addr < PRE_AW'(IMEM_WORDS));
  assign pre_d_hit = pre_we &&  pre_dsel && (pre_addr < PRE_AW'(DMEM_WORDS));

  // fetch
  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

  sc_mem #(.WORDS(IMEM_WORDS), .W(32)) u_imem (
    .clk   (clk),
    .we    (pre_i_hit),
    .waddr (pre_addr[IAW-1:0]),
    .wdata (pre_data),
    .raddr (pc[IAW+1:2]),
    .rdata (instr)
  );

  // decode
  sc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign dst     = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign imm_ext = sext16(instr[15:0]);

  logic [31:0] wb_data;

  sc_regfile #(.NREG(32), .W(32)) u_rf (
    .clk (clk),
    .rst (rst),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rs_data),
    .rd2 (rt_data),
    .we  (ctrl.reg_write),
    .wa  (dst),
    .wd  (wb_data)
  );

  // execute
  assign alu_b = ctrl.b_is_imm ? imm_ext : rt_data;

  sc_alu #(.W(32)) u_alu (
    .a    (rs_data),
    .b    (alu_b),
    .op   (ctrl.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // memory
  assign store_now = ctrl.mem_write && !rst;
  assign dm_we     = pre_d_hit || store_now;
  assign dm_waddr  = pre_d_hit ? pre_addr[DAW-1:0] : alu_y[DAW+1:2];
  assign dm_wval   = pre_d_hit ? pre_data : rt_data;

  sc_mem #(.WORDS(DMEM_WORDS), .W(32)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wval),
    .raddr (alu_y[DAW+1:2]),
    .rdata (dm_rdata)
  );

  // write-back
  assign wb_data = ctrl.wb_from_mem ? dm_rdata : alu_y;

  // next PC
  assign pc4     = pc + 32'd4;
  assign take_br = ctrl.branch && alu_zero;
  assign take_j  = ctrl.jump;

  always_comb begin
    if (take_j)       pc_nxt = jump_target(pc4, instr[25:0]);
    else if (take_br) pc_nxt = branch_target(pc4, instr[15:0]);
    else              pc_nxt = pc4;
  end

  // observation ports
  assign pc_o       = pc;
  assign instr_o    = instr;
  assign rf_we_o    = ctrl.reg_write && !rst;
  assign rf_waddr_o = dst;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = store_now;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rt_data;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rs_data,
  input logic [31:0] rt_data,
  input logic        take_br,
  input logic        take_j,
  input logic        rf_we,
  input logic        dm_we
);

  logic [31:0] pc4;
  logic [5:0]  opc;
  assign pc4 = pc + 32'd4;
  assign opc = instr[31:26];

  assert_pc_reset_R1: assert property (@(posedge clk)
    rst |=> (pc == 32'd0));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!take_br && !take_j) |=> (pc == $past(pc4)));

  assert_x0_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> (rs_data == 32'd0));

  assert_br_equal_R7: assert property (@(posedge clk) disable iff (rst)
    take_br |-> (rs_data == rt_data));

  assert_br_target_R7: assert property (@(posedge clk) disable iff (rst)
    take_br |=> (pc == $past(pc4) + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
    take_j |=> (pc == {$past(pc4[31:28]), $past(instr[25:0]), 2'b00}));

  assert_rf_we_R9: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (opc == OP_RTYPE || opc == OP_LOAD));

  assert_dm_we_R9: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> (opc == OP_STORE));

endmodule

bind sc_core sc_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc      (pc_o),
  .instr   (instr_o),
  .rs_data (rs_data),
  .rt_data (rt_data),
  .take_br (take_br),
  .take_j  (take_j),
  .rf_we   (rf_we_o),
  .dm_we   (dm_we_o)
);

// File: tb/tb_sc_core.sv
module tb_sc_core;

  localparam int CLK_P  = 10;
  localparam int PRE_AW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pre_we = 1'b0;
  logic              pre_dsel = 1'b0;
  logic [PRE_AW-1:0] pre_addr = '0;
  logic [31:0]       pre_data = '0;
  logic [31:0]       pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic              rf_we_o, dm_we_o;
  logic [4:0]        rf_waddr_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  sc_core #(.IMEM_WORDS(32), .DMEM_WORDS(16), .PRE_AW(PRE_AW)) dut (
    .clk (clk), .rst (rst),
    .pre_we (pre_we), .pre_dsel (pre_dsel), .pre_addr (pre_addr), .pre_data (pre_data),
    .pc_o (pc_o), .instr_o (instr_o),
    .rf_we_o (rf_we_o), .rf_waddr_o (rf_waddr_o), .rf_wdata_o (rf_wdata_o),
    .dm_we_o (dm_we_o), .dm_addr_o (dm_addr_o), .dm_wdata_o (dm_wdata_o)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(input int word_idx);
    return {6'h02, 26'(word_idx)};
  endfunction

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
    logic        dwe;
    logic [31:0] da;
    logic [31:0] dd;
  } row_t;

  localparam int NROWS = 17;
  localparam row_t TBL [NROWS] = '{
    '{32'd0,  1'b1, 5'd1,  32'h0000000A, 1'b0, 32'd0,  32'd0},         // R5 lw r1
    '{32'd4,  1'b1, 5'd2,  32'hFFFFFFF3, 1'b0, 32'd0,  32'd0},         // R5 lw r2
    '{32'd8,  1'b1, 5'd3,  32'hFFFFFFFD, 1'b0, 32'd0,  32'd0},         // R3 add
    '{32'd12, 1'b1, 5'd4,  32'h00000017, 1'b0, 32'd0,  32'd0},         // R3 sub
    '{32'd16, 1'b1, 5'd5,  32'h00000002, 1'b0, 32'd0,  32'd0},         // R3 and
    '{32'd20, 1'b1, 5'd6,  32'hFFFFFFFB, 1'b0, 32'd0,  32'd0},         // R3 or
    '{32'd24, 1'b1, 5'd7,  32'h00000001, 1'b0, 32'd0,  32'd0},         // R3 slt signed true
    '{32'd28, 1'b1, 5'd8,  32'h00000000, 1'b0, 32'd0,  32'd0},         // R3 slt false
    '{32'd32, 1'b1, 5'd0,  32'h00000014, 1'b0, 32'd0,  32'd0},         // R4 write to r0
    '{32'd36, 1'b1, 5'd9,  32'h00000000, 1'b0, 32'd0,  32'd0},         // R4 r0 reads zero
    '{32'd40, 1'b0, 5'd0,  32'd0,        1'b1, 32'd12, 32'hFFFFFFFD},  // R6 sw
    '{32'd44, 1'b1, 5'd10, 32'hFFFFFFFD, 1'b0, 32'd0,  32'd0},         // R5 R6 lw back
    '{32'd48, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},         // R7 not taken
    '{32'd52, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},         // R7 taken
    '{32'd64, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},         // R7 target, R8 jump
    '{32'd80, 1'b0, 5'd0,  32'd0,        1'b0, 32'd0,  32'd0},         // R8 target, R7 backward
    '{32'd0,  1'b1, 5'd1,  32'h0000000A, 1'b0, 32'd0,  32'd0}          // R7 back at 0
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic sel, input int idx, input logic [31:0] val);
    @(negedge clk);
    pre_we   = 1'b1;
    pre_dsel = sel;
    pre_addr = PRE_AW'(idx);
    pre_data = val;
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] prog [21];
    logic [31:0] poison;
    poison   = enc_i(6'h2B, 0, 1, 16'd0);  // stray store if ever executed
    prog[0]  = enc_i(6'h23, 0, 1, 16'd4);
    prog[1]  = enc_i(6'h23, 0, 2, 16'd8);
    prog[2]  = enc_r(1, 2, 3, 6'h20);
    prog[3]  = enc_r(1, 2, 4, 6'h22);
    prog[4]  = enc_r(1, 2, 5, 6'h24);
    prog[5]  = enc_r(1, 2, 6, 6'h25);
    prog[6]  = enc_r(2, 1, 7, 6'h2A);
    prog[7]  = enc_r(1, 2, 8, 6'h2A);
    prog[8]  = enc_r(1, 1, 0, 6'h20);
    prog[9]  = enc_r(0, 0, 9, 6'h20);
    prog[10] = enc_i(6'h2B, 1, 3, 16'd2);
    prog[11] = enc_i(6'h23, 0, 10, 16'd12);
    prog[12] = enc_i(6'h04, 1, 2, 16'd5);
    prog[13] = enc_i(6'h04, 3, 10, 16'd2);
    prog[14] = poison;
    prog[15] = poison;
    prog[16] = enc_j(20);
    prog[17] = poison;
    prog[18] = poison;
    prog[19] = poison;
    prog[20] = enc_i(6'h04, 0, 0, 16'hFFEB);

    // R10 preload both arrays while reset is held
    for (int i = 0; i < 21; i++) preload(1'b0, i, prog[i]);
    preload(1'b1, 1, 32'h0000000A);
    preload(1'b1, 2, 32'hFFFFFFF3);
    @(negedge clk);
    pre_we = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", "pc in reset", pc_o, 32'd0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NROWS; i++) begin
      if (i > 0) @(negedge clk);
      #1;
      chk("R2/R7/R8", "pc", pc_o, TBL[i].pc);
      chk("R9", "rf_we", {31'd0, rf_we_o}, {31'd0, TBL[i].we});
      chk("R9", "dm_we", {31'd0, dm_we_o}, {31'd0, TBL[i].dwe});
      if (TBL[i].we) begin
        chk("R3/R4/R5", "waddr", {27'd0, rf_waddr_o}, {27'd0, TBL[i].wa});
        chk("R3/R4/R5", "wdata", rf_wdata_o, TBL[i].wd);
      end
      if (TBL[i].dwe) begin
        chk("R6", "dm_addr", dm_addr_o, TBL[i].da);
        chk("R6", "dm_wdata", dm_wdata_o, TBL[i].dd);
      end
    end

    // directed: mid-run reset, fresh preload, unknown opcode, cleared registers
    @(negedge clk);
    rst = 1'b1;
    preload(1'b0, 0, enc_i(6'h23, 0, 11, 16'd20));
    preload(1'b0, 1, 32'hFC000000);
    preload(1'b1, 5, 32'h12345678);
    @(negedge clk);
    pre_we = 1'b0;
    #1;
    chk("R1", "pc after mid-run reset", pc_o, 32'd0);
    rst = 1'b0;
    #1;
    chk("R10", "rf_we preload load", {31'd0, rf_we_o}, 32'd1);
    chk("R10", "waddr preload load", {27'd0, rf_waddr_o}, 32'd11);
    chk("R10", "data preloaded", rf_wdata_o, 32'h12345678);
    @(negedge clk);
    #1;
    chk("R2", "pc after load", pc_o, 32'd4);
    chk("R9", "unknown op rf_we", {31'd0, rf_we_o}, 32'd0);
    chk("R9", "unknown op dm_we", {31'd0, dm_we_o}, 32'd0);
    @(negedge clk);
    #1;
    chk("R2", "pc after unknown op", pc_o, 32'd8);
    chk("R1", "regs cleared, add r1+r2", rf_wdata_o, 32'd0);
    chk("R3", "add dest r3", {27'd0, rf_waddr_o}, 32'd3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule